// File: doc/BRIEF.md
# Three-Source Interrupt Flag and Pin Controller

This block gathers three interrupt causes (watchdog expiry, alarm match and supply failure) into a flags byte and one shared interrupt pin. Every cause records itself in its own sticky flag, whatever the configuration. A per-cause enable in the control byte decides whether that cause also activates the pin. Software reads the flags byte through a read strobe, and that read clears the flags.

The pin is configurable in two ways. Its electrical form is either a push-pull output that is driven high when active, or an open-drain output that pulls low when active and floats otherwise. Its timing is either a pulse that lasts a parameterised number of ticks of a slow time base, or a level that holds until the flags byte is read. The block provides a drive value and an output enable, and the pad logic combines them.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, the flags byte reads 0x00, `pin_oe_o` is 0 and `pin_o` is 0.
- R2: A write to the control byte stores bit 7 (watchdog enable), bit 6 (alarm enable), bit 5 (supply-fail enable), bit 3 (polarity, 1 = push-pull active high) and bit 2 (timing, 1 = pulse). Bits 4, 1 and 0 always read 0. The new value is visible the cycle after the write.
- R3: A one-cycle event on a source sets its flag in the cycle after the event, whether or not its enable is set. The watchdog flag sits in bit 7, the alarm flag in bit 6 and the supply-fail flag in bit 5. All other bits read 0.
- R4: While `flag_re_i` is high, `flag_rdata_o` shows the current flags. On the next cycle all three flags are clear.
- R5: An event that arrives in the same cycle as a flags read leaves its own flag set after the read.
- R6: The pin becomes active only after an event from a source whose enable bit is 1. An event from a disabled source leaves the pin inactive.
- R7: With polarity 1, `pin_oe_o` is 1 at all times and `pin_o` equals the active state.
- R8: With polarity 0, `pin_o` is 0 at all times and `pin_oe_o` is 1 only while the pin is active.
- R9: In pulse timing, an enabled event makes the pin active. The pin stays active through the next PULSE_TICKS-1 ticks of `tick_i` and goes inactive on the PULSE_TICKS-th tick (default 7).
- R10: An enabled event during a pulse restarts the tick count from PULSE_TICKS.
- R11: In level timing, an enabled event makes the pin active. The pin stays active regardless of ticks until a flags read, and is inactive on the cycle after the read.
- R12: In level timing, an enabled event in the same cycle as a flags read keeps the pin active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe of the slow time base |
| wdog_evt_i | input | 1 | Watchdog expiry event |
| alarm_evt_i | input | 1 | Alarm match event |
| pfail_evt_i | input | 1 | Supply-fail event |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data |
| ctl_rdata_o | output | 8 | Control byte read value |
| flag_re_i | input | 1 | Flags read strobe, clears flags |
| flag_rdata_o | output | 8 | Flags byte |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
Two pairs of functions can land in the same cycle. A source event can collide with the flags read that clears it, and an enabled event can collide with a tick in the pulse counter. The bench raises the event strobe and the read strobe on the same edge, then checks that the colliding flag is still set and, in level timing, that the pin is still active. For the restart case, the bench fires a second enabled event part way through a pulse and checks that the pin outlasts the first pulse by exactly the restarted tick count.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
   localparam int SRC_N      = 3;
   localparam int BYTE_W     = 8;
   // source index: 2 = watchdog, 1 = alarm, 0 = supply fail
   localparam int SRC_WDOG   = 2;
   localparam int SRC_ALARM  = 1;
   localparam int SRC_PFAIL  = 0;
   // control byte field positions
   localparam int CTL_EN_LSB = 5;
   localparam int CTL_POL    = 3;
   localparam int CTL_PULSE  = 2;
   // flags byte: flags occupy the same upper bits as the enables
   localparam int FLG_LSB    = 5;

   typedef struct packed {
      logic [SRC_N-1:0] en;
      logic             pol;
      logic             pulse;
   } irq_ctl_t;

   function automatic logic [BYTE_W-1:0] ctl_pack(irq_ctl_t c);
      logic [BYTE_W-1:0] b;
      b = '0;
      b[CTL_EN_LSB +: SRC_N] = c.en;
      b[CTL_POL]             = c.pol;
      b[CTL_PULSE]           = c.pulse;
      return b;
   endfunction

   function automatic irq_ctl_t ctl_unpack(logic [BYTE_W-1:0] b);
      irq_ctl_t c;
      c.en    = b[CTL_EN_LSB +: SRC_N];
      c.pol   = b[CTL_POL];
      c.pulse = b[CTL_PULSE];
      return c;
   endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int SRC_N = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] evt_i,
   input  logic             clr_i,
   output logic [SRC_N-1:0] flag_o
);
   generate
      if (SRC_N < 1) begin : g_bad_src
         $error("irq_flag_bank: SRC_N must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < SRC_N; gi++) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (evt_i[gi])  flag_q <= 1'b1;   // event wins over clear
            else if (clr_i)      flag_q <= 1'b0;
         end
         assign flag_o[gi] = flag_q;

         assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[gi] |=> flag_o[gi]);
         assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !evt_i[gi]) |=> !flag_o[gi]);
         assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[gi] && !clr_i) |=> flag_o[gi]);
      end
   endgenerate
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
   parameter int PULSE_TICKS = 7,
   localparam int CNT_W = $clog2(PULSE_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic tick_i,
   output logic active_o
);
   generate
      if (PULSE_TICKS < 1) begin : g_bad_len
         $error("irq_pulse_timer: PULSE_TICKS must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_TICKS);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (load_i)                   cnt_q <= LOAD_VAL;    // restart wins over tick
      else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = (cnt_q != '0);

   assert_cnt_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD_VAL);
   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_q == LOAD_VAL);
   assert_rise_from_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o) |-> $past(load_i));
   assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_level_hold.sv
module irq_level_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic active_o
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      lvl_q <= 1'b0;
      else if (set_i)  lvl_q <= 1'b1;   // new event outranks the read
      else if (clr_i)  lvl_q <= 1'b0;
   end

   assign active_o = lvl_q;

   assert_level_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q && !clr_i) |=> lvl_q);
   assert_level_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !lvl_q);
   assert_collide_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> lvl_q);
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
   parameter bit ALLOW_PUSH_PULL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic pol_i,
   output logic pin_o,
   output logic oe_o
);
   logic push_pull;

   generate
      if (ALLOW_PUSH_PULL) begin : g_both
         assign push_pull = pol_i;
      end else begin : g_od_only
         assign push_pull = 1'b0;
      end
   endgenerate

   always_comb begin
      if (push_pull) begin
         pin_o = active_i;
         oe_o  = 1'b1;
      end else begin
         pin_o = 1'b0;
         oe_o  = active_i;
      end
   end

   assert_pushpull_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push_pull |-> (oe_o && pin_o == active_i));
   assert_opendrain_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !push_pull |-> (!pin_o && oe_o == active_i));
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
   import irq_ctl_pkg::*;
#(
   parameter int PULSE_TICKS     = 7,
   parameter bit ALLOW_PUSH_PULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wdog_evt_i,
   input  logic              alarm_evt_i,
   input  logic              pfail_evt_i,
   input  logic              ctl_we_i,
   input  logic [BYTE_W-1:0] ctl_wdata_i,
   output logic [BYTE_W-1:0] ctl_rdata_o,
   input  logic              flag_re_i,
   output logic [BYTE_W-1:0] flag_rdata_o,
   output logic              pin_o,
   output logic              pin_oe_o
);
   localparam int FLG_PAD = FLG_LSB;

   irq_ctl_t         ctl_q;
   logic [SRC_N-1:0] evt_vec;
   logic [SRC_N-1:0] flags;
   logic             hit;
   logic             pulse_act;
   logic             level_act;
   logic             pin_act;

   always_ff @(posedge clk) begin
      if (!rst_n)        ctl_q <= '0;
      else if (ctl_we_i) ctl_q <= ctl_unpack(ctl_wdata_i);
   end
   assign ctl_rdata_o = ctl_pack(ctl_q);

   always_comb begin
      evt_vec            = '0;
      evt_vec[SRC_WDOG]  = wdog_evt_i;
      evt_vec[SRC_ALARM] = alarm_evt_i;
      evt_vec[SRC_PFAIL] = pfail_evt_i;
   end

   assign hit = |(evt_vec & ctl_q.en);

   irq_flag_bank #(.SRC_N(SRC_N)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_vec),
      .clr_i  (flag_re_i),
      .flag_o (flags)
   );

   assign flag_rdata_o = {flags, {FLG_PAD{1'b0}}};

   irq_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (hit && ctl_q.pulse),
      .tick_i   (tick_i),
      .active_o (pulse_act)
   );

   irq_level_hold u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (hit && !ctl_q.pulse),
      .clr_i    (flag_re_i),
      .active_o (level_act)
   );

   assign pin_act = ctl_q.pulse ? pulse_act : level_act;

   irq_pin_drive #(.ALLOW_PUSH_PULL(ALLOW_PUSH_PULL)) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (pin_act),
      .pol_i    (ctl_q.pol),
      .pin_o    (pin_o),
      .oe_o     (pin_oe_o)
   );

   assert_level_rise_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(level_act) |-> $past(|(evt_vec & ctl_q.en)));
   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata_o[4] == 1'b0) && (ctl_rdata_o[1:0] == 2'b00) && (flag_rdata_o[FLG_PAD-1:0] == '0));
endmodule

// File: tb/irq_pin_ctrl_bench.sv
module irq_pin_ctrl_bench;
   localparam int PT = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       wdog = 1'b0, alarm = 1'b0, pfail = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [7:0] ctl_rdata;
   logic       flag_re = 1'b0;
   logic [7:0] flag_rdata;
   logic       pin_o, pin_oe;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   irq_pin_ctrl #(.PULSE_TICKS(PT)) u_irq_pin_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .wdog_evt_i(wdog), .alarm_evt_i(alarm), .pfail_evt_i(pfail),
      .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
      .flag_re_i(flag_re), .flag_rdata_o(flag_rdata),
      .pin_o(pin_o), .pin_oe_o(pin_oe)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_ctl(logic [7:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   // one-cycle strobe of events {wdog,alarm,pfail}, optional read and tick
   task automatic strobe(logic [2:0] ev, logic rd, logic tk, output logic [7:0] seen);
      {wdog, alarm, pfail} = ev;
      flag_re = rd; tick_i = tk;
      #1 seen = flag_rdata;
      @(negedge clk);
      {wdog, alarm, pfail} = 3'b000;
      flag_re = 1'b0; tick_i = 1'b0;
   endtask

   task automatic ticks(int n);
      logic [7:0] s;
      for (int i = 0; i < n; i++) strobe(3'b000, 1'b0, 1'b1, s);
   endtask

   task automatic t_reset();
      check("R1 ctl", ctl_rdata, 8'h00);
      check("R1 flags", flag_rdata, 8'h00);
      check("R1 pin", {6'b0, pin_oe, pin_o}, 8'h00);
   endtask

   task automatic t_ctl();
      wr_ctl(8'hFF);
      check("R2 readback", ctl_rdata, 8'hEC);
      wr_ctl(8'h00);
      check("R2 cleared", ctl_rdata, 8'h00);
   endtask

   task automatic t_flags();
      logic [7:0] s;
      strobe(3'b100, 1'b0, 1'b0, s);
      check("R3 wdog flag", flag_rdata, 8'h80);
      strobe(3'b011, 1'b0, 1'b0, s);
      check("R3 all flags", flag_rdata, 8'hE0);
      check("R6 disabled no pin", {6'b0, pin_oe, pin_o}, 8'h00);
      strobe(3'b000, 1'b1, 1'b0, s);
      check("R4 read value", s, 8'hE0);
      check("R4 cleared", flag_rdata, 8'h00);
      strobe(3'b100, 1'b0, 1'b0, s);
      strobe(3'b010, 1'b1, 1'b0, s);
      check("R5 read sees old", s, 8'h80);
      check("R5 collide kept", flag_rdata, 8'h40);
      strobe(3'b000, 1'b1, 1'b0, s);
   endtask

   task automatic t_enable_gate();
      logic [7:0] s;
      wr_ctl(8'h48);                 // alarm only, push-pull, level
      strobe(3'b101, 1'b0, 1'b0, s);
      check("R6 wdog+pfail gated", {6'b0, pin_oe, pin_o}, 8'h02);
      check("R3 flags w/o enable", flag_rdata, 8'hA0);
      strobe(3'b010, 1'b0, 1'b0, s);
      check("R6 alarm asserts", {6'b0, pin_oe, pin_o}, 8'h03);
      strobe(3'b000, 1'b1, 1'b0, s);
   endtask

   task automatic t_pulse();
      logic [7:0] s;
      wr_ctl(8'hEC);                 // all enabled, push-pull, pulse
      strobe(3'b100, 1'b0, 1'b0, s);
      check("R9 pulse start", {7'b0, pin_o}, 8'h01);
      ticks(PT - 1);
      check("R9 pulse before end", {7'b0, pin_o}, 8'h01);
      ticks(1);
      check("R9 pulse end", {7'b0, pin_o}, 8'h00);
      check("R7 oe pushpull", {7'b0, pin_oe}, 8'h01);
      strobe(3'b001, 1'b0, 1'b0, s);
      ticks(3);
      strobe(3'b001, 1'b0, 1'b1, s);   // event with tick: restart
      ticks(PT - 1);
      check("R10 restarted still on", {7'b0, pin_o}, 8'h01);
      ticks(1);
      check("R10 restarted ends", {7'b0, pin_o}, 8'h00);
      strobe(3'b000, 1'b1, 1'b0, s);
   endtask

   task automatic t_level();
      logic [7:0] s;
      wr_ctl(8'hE8);                 // all enabled, push-pull, level
      strobe(3'b010, 1'b0, 1'b0, s);
      ticks(PT + 3);
      check("R11 level holds", {7'b0, pin_o}, 8'h01);
      strobe(3'b000, 1'b1, 1'b0, s);
      check("R11 read releases", {7'b0, pin_o}, 8'h00);
      strobe(3'b100, 1'b0, 1'b0, s);
      strobe(3'b001, 1'b1, 1'b0, s);
      check("R12 collide keeps pin", {7'b0, pin_o}, 8'h01);
      check("R12 collide flag", flag_rdata, 8'h20);
      strobe(3'b000, 1'b1, 1'b0, s);
      check("R12 later read releases", {7'b0, pin_o}, 8'h00);
   endtask

   task automatic t_open_drain();
      logic [7:0] s;
      wr_ctl(8'hE0);                 // all enabled, open drain, level
      check("R8 idle float", {6'b0, pin_oe, pin_o}, 8'h00);
      strobe(3'b001, 1'b0, 1'b0, s);
      check("R8 active pulls low", {6'b0, pin_oe, pin_o}, 8'h02);
      strobe(3'b000, 1'b1, 1'b0, s);
      check("R8 released", {6'b0, pin_oe, pin_o}, 8'h00);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_ctl();
      t_flags();
      t_enable_gate();
      t_pulse();
      t_level();
      t_open_drain();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule